// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking a two-level page table with 4 KB pages. A client presents a directory base address and a virtual address with a one-cycle start strobe. The walker fetches the directory entry and then the table entry through a simple memory read port. It checks the present flag of each entry and ends with either a physical address or a fault that names the level where the walk stopped.

The read port is a one-cycle request pulse with an address. The reply is a data word qualified by a valid strobe, which may arrive any number of cycles later. The walker holds the request address steady while it waits. A completion strobe lasts one cycle and carries the result. The walker then returns to idle and will take a new start on the following cycle.

Top module: `pt_walker`

## Requirements
- R1: During and after synchronous reset, `busy_o`, `done_o`, `fault_o` and `mem_req_o` are low.
- R2: A start in idle issues a read on the next cycle. Its address is the directory base with its low 12 bits forced to zero, plus 4 times virtual address bits 31:22.
- R3: A start strobe that arrives while a walk is in progress is ignored. The running walk completes with its own result, and no extra read is issued.
- R4: If bit 0 (present) of the directory entry is 0, the walk ends with `fault_o`=1 and `fault_lvl_o`=0, and no second read is issued.
- R5: If the directory entry is present, a second read is issued. Its address is the directory entry ANDed with 0xFFFFF000, plus 4 times virtual address bits 21:12.
- R6: If bit 0 of the table entry is 0, the walk ends with `fault_o`=1 and `fault_lvl_o`=1.
- R7: On success, `fault_o`=0 and `paddr_o` equals the table entry ANDed with 0xFFFFF000, ORed with virtual address bits 11:0.
- R8: Each read request is high for exactly one cycle. `mem_addr_o` stays stable until the reply arrives, and the walker waits any number of cycles for `mem_rvalid_i`.
- R9: `done_o` is high for exactly one cycle at the end of every walk. On the next cycle `busy_o` is low and a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk (honoured only while idle) |
| dir_base_i | input | 32 | Directory base address |
| vaddr_i | input | 32 | Virtual address to translate |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Read address |
| mem_rvalid_i | input | 1 | Read reply valid |
| mem_rdata_i | input | 32 | Read reply data |
| done_o | output | 1 | One-cycle completion strobe |
| fault_o | output | 1 | Walk ended on a non-present entry (valid with done_o) |
| fault_lvl_o | output | 1 | 0 = directory level, 1 = table level |
| paddr_o | output | 32 | Translated physical address |

## Verification
The sweep covers all 1024 directory indices. Each walk uses nonzero flag bits in both entries and junk in the low bits of the base, so a walker that forgets to mask would produce wrong request addresses or a wrong physical address. Present flags are cleared at both levels in a fixed pattern. A walker that ignored the directory flag would issue a spurious second read, and one that mixed up the levels would report the wrong fault code. Reply latency changes from one to four cycles, and stray starts are injected mid-walk. A walker that took a reply during its own request cycle, or restarted on a busy start, would show an extra read or a wrong result. The two worked translations, one successful and one directory fault, are replayed exactly.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_RD_TBL,
    ST_DONE,
    ST_FAULT
  } walk_state_t;

  localparam logic FLT_LVL_DIR = 1'b0;
  localparam logic FLT_LVL_TBL = 1'b1;

endpackage

// File: rtl/ptw_entry_addr.sv
// Entry address: aligned table base plus index scaled by the entry size.
module ptw_entry_addr #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 10,
  parameter int OFF_W      = 12,
  parameter int ENTRY_LOG2 = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

  logic [ADDR_W-1:0] idx_ext;
  logic [ADDR_W-1:0] scaled;

  always_comb begin
    idx_ext = {{(ADDR_W-IDX_W){1'b0}}, idx_i};
    scaled  = idx_ext << ENTRY_LOG2;
    addr_o  = (base_i & ALIGN_MASK) + scaled;
  end
endmodule

// File: rtl/ptw_entry_decode.sv
// Splits a fetched entry into its present flag and its frame base.
module ptw_entry_decode #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 12,
  parameter int PRES_BIT = 0
) (
  input  logic [ADDR_W-1:0] entry_i,
  output logic              present_o,
  output logic [ADDR_W-1:0] frame_o
);
  localparam logic [ADDR_W-1:0] FRAME_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

  always_comb begin
    present_o = entry_i[PRES_BIT];
    frame_o   = entry_i & FRAME_MASK;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 12,
  parameter int IDX_W      = 10,
  parameter int ENTRY_LOG2 = 2,
  parameter int PRES_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dir_base_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              fault_o,
  output logic              fault_lvl_o,
  output logic [ADDR_W-1:0] paddr_o
);
  import ptw_pkg::*;

  localparam int DIR_LSB = OFF_W + IDX_W;
  localparam int LO_W    = OFF_W + IDX_W;

  walk_state_t       state_q;
  logic [LO_W-1:0]   va_lo_q;
  logic              req_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] paddr_q;
  logic              done_q;
  logic              fault_q;
  logic              lvl_q;

  logic              is_idle;
  logic              in_read;
  logic              rsp_take;
  logic [ADDR_W-1:0] sel_base;
  logic [IDX_W-1:0]  sel_idx;
  logic [ADDR_W-1:0] ent_addr;
  logic              ent_present;
  logic [ADDR_W-1:0] ent_frame;

  always_comb begin
    is_idle  = (state_q == ST_IDLE);
    in_read  = (state_q == ST_RD_DIR) || (state_q == ST_RD_TBL);
    rsp_take = in_read && mem_rvalid_i && !req_q;
    if (is_idle) begin
      sel_base = dir_base_i;
      sel_idx  = vaddr_i[DIR_LSB +: IDX_W];
    end else begin
      sel_base = ent_frame;
      sel_idx  = va_lo_q[OFF_W +: IDX_W];
    end
  end

  ptw_entry_addr #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENTRY_LOG2(ENTRY_LOG2)
  ) u_addr (
    .base_i(sel_base),
    .idx_i (sel_idx),
    .addr_o(ent_addr)
  );

  ptw_entry_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PRES_BIT(PRES_BIT)
  ) u_dec (
    .entry_i  (mem_rdata_i),
    .present_o(ent_present),
    .frame_o  (ent_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      va_lo_q <= '0;
      req_q   <= 1'b0;
      addr_q  <= '0;
      paddr_q <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      lvl_q   <= FLT_LVL_DIR;
    end else begin
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            va_lo_q <= vaddr_i[LO_W-1:0];
            addr_q  <= ent_addr;
            req_q   <= 1'b1;
            state_q <= ST_RD_DIR;
          end
        end
        ST_RD_DIR: begin
          if (rsp_take) begin
            if (ent_present) begin
              addr_q  <= ent_addr;
              req_q   <= 1'b1;
              state_q <= ST_RD_TBL;
            end else begin
              fault_q <= 1'b1;
              done_q  <= 1'b1;
              lvl_q   <= FLT_LVL_DIR;
              state_q <= ST_FAULT;
            end
          end
        end
        ST_RD_TBL: begin
          if (rsp_take) begin
            done_q <= 1'b1;
            if (ent_present) begin
              paddr_q <= ent_frame | {{(ADDR_W-OFF_W){1'b0}}, va_lo_q[OFF_W-1:0]};
              state_q <= ST_DONE;
            end else begin
              fault_q <= 1'b1;
              lvl_q   <= FLT_LVL_TBL;
              state_q <= ST_FAULT;
            end
          end
        end
        ST_DONE, ST_FAULT: state_q <= ST_IDLE;
        default:           state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = !is_idle;
  assign mem_req_o   = req_q;
  assign mem_addr_o  = addr_q;
  assign done_o      = done_q;
  assign fault_o     = fault_q;
  assign fault_lvl_o = lvl_q;
  assign paddr_o     = paddr_q;

  // R8: request is a one-cycle pulse
  assert_req_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !mem_req_o);

  // R8: requests only during a walk
  assert_req_in_walk_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> busy_o);

  // R8: address held while waiting for the reply
  assert_addr_held_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !mem_req_o && !done_o) |-> $stable(mem_addr_o));

  // R2: a start in idle issues a request next cycle
  assert_start_issues_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> mem_req_o);

  // R9: completion returns to idle on the next cycle
  assert_done_to_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!busy_o && !done_o));

  // R4: fault is only reported together with completion
  assert_fault_with_done_R4: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> done_o);

  // R1: quiet outputs right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!busy_o && !done_o && !mem_req_o && !fault_o));

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] dir_base_i = '0;
  logic [31:0] vaddr_i = '0;
  logic        busy_o, mem_req_o, done_o, fault_o, fault_lvl_o;
  logic [31:0] mem_addr_o, paddr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int errors = 0;
  int checks = 0;
  int lat_cfg = 1;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] req_log [$];

  always #4 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst(rst), .start_i(start_i), .dir_base_i(dir_base_i),
    .vaddr_i(vaddr_i), .busy_o(busy_o), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .done_o(done_o), .fault_o(fault_o),
    .fault_lvl_o(fault_lvl_o), .paddr_o(paddr_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: replies lat_cfg cycles after each request
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid_i = 1'b0;
      if (mem_req_o) begin
        logic [31:0] a;
        a = mem_addr_o;
        req_log.push_back(a);
        repeat (lat_cfg) @(negedge clk);
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem.exists(a) ? mem[a] : 32'h0;
      end
    end
  end

  task automatic walk(input logic [31:0] base, input logic [31:0] va,
                      input int lat, input logic [31:0] dval,
                      input logic [31:0] tval, input bit poke);
    logic [31:0] daddr, taddr, exp_pa;
    int nreq;
    bit got;
    daddr = {base[31:12], 12'h0} + {20'h0, va[31:22], 2'b00};
    taddr = {dval[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
    exp_pa = {tval[31:12], va[11:0]};
    mem[daddr] = dval;
    mem[taddr] = tval;
    nreq = dval[0] ? 2 : 1;
    lat_cfg = lat;
    req_log.delete();
    @(negedge clk);
    dir_base_i = base; vaddr_i = va; start_i = 1'b1;
    @(negedge clk);
    start_i = poke;
    if (poke) begin vaddr_i = ~va; dir_base_i = base ^ 32'h0040_0000; end
    @(negedge clk);
    start_i = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (done_o) begin got = 1'b1; break; end
    end
    check(got, "R9 walk completes", {31'h0, got}, 32'h1);
    if (!got) return;
    check(req_log.size() == nreq, poke ? "R3 read count with busy start" : "R4 read count",
          req_log.size(), nreq);
    if (req_log.size() > 0)
      check(req_log[0] == daddr, "R2 directory address", req_log[0], daddr);
    if (nreq == 2 && req_log.size() > 1)
      check(req_log[1] == taddr, "R5 table address", req_log[1], taddr);
    if (!dval[0]) begin
      check(fault_o && fault_lvl_o == 1'b0, "R4 directory fault", {30'h0, fault_o, fault_lvl_o}, 32'h2);
    end else if (!tval[0]) begin
      check(fault_o && fault_lvl_o == 1'b1, "R6 table fault", {30'h0, fault_o, fault_lvl_o}, 32'h3);
    end else begin
      check(!fault_o, "R7 no fault", {31'h0, fault_o}, 32'h0);
      check(paddr_o == exp_pa, poke ? "R3 result kept" : "R7 physical address", paddr_o, exp_pa);
    end
    @(negedge clk);
    check(!done_o && !busy_o, "R9 one-cycle done then idle", {30'h0, done_o, busy_o}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !mem_req_o && !fault_o, "R1 reset state",
          {28'h0, busy_o, done_o, mem_req_o, fault_o}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !mem_req_o, "R1 idle after reset", {30'h0, busy_o, mem_req_o}, 32'h0);

    // worked translations
    mem[32'h0005_5004] = 32'h8974_d003;
    walk(32'h0c23_b000, 32'h0800_16ba, 1, 32'h0005_5d01, 32'h8974_d003, 1'b0);
    check(paddr_o == 32'h8974_d6ba, "R7 worked example", paddr_o, 32'h8974_d6ba);
    walk(32'h0c23_b000, 32'h9fd2_8c10, 2, 32'h2314_d222, 32'h0, 1'b0);

    // sweep over every directory index (R8: latency 1..4)
    for (int d = 0; d < 1024; d++) begin
      logic [31:0] base, va, dv, tv;
      int t, off;
      t = (d * 37 + 5) % 1024;
      off = (d * 131) % 4096;
      va = {d[9:0], t[9:0], off[11:0]};
      base = {20'(32'h0C000 + d * 3), 12'(d * 17)};
      dv = {20'(32'h10000 + d * 5), 12'hA5E | {11'h0, (d % 4) != 3}};
      tv = {20'(32'h80000 ^ (d * 977)), 12'h3F2 | {11'h0, (d % 7) != 6}};
      walk(base, va, 1 + d % 4, dv, tv, (d % 8) == 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule